// File: doc/BRIEF.md
# Two-Level Multiplexer Logic Element

This block is a small configurable logic cell built only from 2:1 multiplexers. Its logic is set by which signals are tied to which pins, so it can act as a signal router or as a gate. Four data inputs feed two first-level multiplexers. A final multiplexer then picks one of their results. No multiplexer select comes straight from a pin: two small fixed gates combine the four control inputs first.

Both first-level multiplexers share one select, which is the AND of control bits 0 and 1. The final select is the OR of control bits 2 and 3. Gating the selects this way gives the cell more functions than plain selects would: for example, tying data pins to constants turns it into wide AND/OR terms. The element has no clock, no reset and no state. Its output follows its present inputs through combinational logic only.

Top module: `mux_logic_elem`

## Requirements
- R1: Each 2:1 stage passes its lower input when its select is 0 and its upper input when its select is 1. The first-level stages pair (dIn0, dIn1) and (dIn2, dIn3). The final stage takes the (dIn0, dIn1) result when its select is 0.
- R2: Both first-level stages use a single shared select, equal to ctrlIn[0] AND ctrlIn[1].
- R3: The final-stage select equals ctrlIn[2] OR ctrlIn[3].
- R4: When ctrlIn[0]&ctrlIn[1] is 0 and ctrlIn[2]|ctrlIn[3] is 0, dataOut equals dIn0.
- R5: When ctrlIn[0]&ctrlIn[1] is 1 and ctrlIn[2]|ctrlIn[3] is 0, dataOut equals dIn1.
- R6: When ctrlIn[0]&ctrlIn[1] is 0 and ctrlIn[2]|ctrlIn[3] is 1, dataOut equals dIn2.
- R7: When ctrlIn[0]&ctrlIn[1] is 1 and ctrlIn[2]|ctrlIn[3] is 1, dataOut equals dIn3.
- R8: The element holds no state. The same input vector gives the same dataOut whatever was applied before, and dataOut settles in the cycle the inputs change.
- R9: Data inputs that the control setting does not select have no effect on dataOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dIn0 | input | DATA_W | Data input, lower leg of the first pair |
| dIn1 | input | DATA_W | Data input, upper leg of the first pair |
| dIn2 | input | DATA_W | Data input, lower leg of the second pair |
| dIn3 | input | DATA_W | Data input, upper leg of the second pair |
| ctrlIn | input | 4 | Control bits; [1:0] are ANDed into the first-level select, [3:2] are ORed into the final select |
| dataOut | output | DATA_W | Selected data value |

## Verification
The checker watches every change of the inputs. It checks that the output equals the data input chosen by each of the four select combinations, and that each internal select strobe is consistent with the control bits it comes from. Two things only the bench's scenarios can show. The first is that the cell has no memory: the same vector is replayed after different histories. The second is that unselected inputs have no effect: those inputs are toggled while the control setting is held. The bench also walks all 256 combinations of the eight one-bit inputs against a behavioural model.

// File: rtl/lem_pkg.sv
package lem_pkg;
  // Strobes the control half hands to the datapath half.
  typedef struct packed {
    logic firstSel;  // shared select of both first-level stages
    logic finalSel;  // select of the output stage
  } lemStrobes_t;

  localparam int CTRL_W = 4;
  localparam int NUM_LEGS = 4;
  localparam int NUM_PAIRS = NUM_LEGS / 2;
endpackage

// File: rtl/lem_mux2.sv
module lem_mux2 #(
  parameter int W = 1
) (
  input  logic [W-1:0] legLo,
  input  logic [W-1:0] legHi,
  input  logic         sel,
  output logic [W-1:0] y
);
  always_comb begin
    if (sel) y = legHi;
    else     y = legLo;
  end
endmodule

// File: rtl/lem_ctrl.sv
module lem_ctrl
  import lem_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrlIn,
  output lemStrobes_t       strobes
);
  // Fixed gating in front of the selects.
  always_comb begin
    strobes.firstSel = ctrlIn[0] & ctrlIn[1];
    strobes.finalSel = ctrlIn[2] | ctrlIn[3];
  end
endmodule

// File: rtl/lem_dpath.sv
module lem_dpath
  import lem_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic [NUM_LEGS-1:0][DATA_W-1:0] legs,
  input  lemStrobes_t                     strobes,
  output logic [DATA_W-1:0]               dataOut
);
  logic [NUM_PAIRS-1:0][DATA_W-1:0] pairOut;

  // First level: one stage per pair of legs, all sharing one select.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_first
    lem_mux2 #(.W(DATA_W)) u_stage (
      .legLo(legs[2*p]),
      .legHi(legs[2*p+1]),
      .sel  (strobes.firstSel),
      .y    (pairOut[p])
    );
  end

  // Second level: picks between the two pair results.
  lem_mux2 #(.W(DATA_W)) u_final (
    .legLo(pairOut[0]),
    .legHi(pairOut[1]),
    .sel  (strobes.finalSel),
    .y    (dataOut)
  );
endmodule

// File: rtl/mux_logic_elem.sv
module mux_logic_elem
  import lem_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic [DATA_W-1:0] dIn0,
  input  logic [DATA_W-1:0] dIn1,
  input  logic [DATA_W-1:0] dIn2,
  input  logic [DATA_W-1:0] dIn3,
  input  logic [3:0]        ctrlIn,
  output logic [DATA_W-1:0] dataOut
);
  lemStrobes_t strobes;
  logic [NUM_LEGS-1:0][DATA_W-1:0] legs;

  assign legs = {dIn3, dIn2, dIn1, dIn0};

  lem_ctrl u_ctrl (
    .ctrlIn (ctrlIn),
    .strobes(strobes)
  );

  lem_dpath #(.DATA_W(DATA_W)) u_dpath (
    .legs   (legs),
    .strobes(strobes),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/lem_chk.sv
module lem_chk
  import lem_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input logic [DATA_W-1:0] dIn0,
  input logic [DATA_W-1:0] dIn1,
  input logic [DATA_W-1:0] dIn2,
  input logic [DATA_W-1:0] dIn3,
  input logic [3:0]        ctrlIn,
  input logic [DATA_W-1:0] dataOut,
  input lemStrobes_t       strobes
);
  always_comb begin
    // R2
    first_sel_needs_both_chk: assert (!strobes.firstSel || (ctrlIn[0] && ctrlIn[1]));
    // R3
    final_sel_needs_one_chk: assert (strobes.finalSel || !(ctrlIn[2] || ctrlIn[3]));
    // R4
    pick_leg0_chk: assert (!(!(ctrlIn[0] && ctrlIn[1]) && !(ctrlIn[2] || ctrlIn[3])) || dataOut == dIn0);
    // R5
    pick_leg1_chk: assert (!((ctrlIn[0] && ctrlIn[1]) && !(ctrlIn[2] || ctrlIn[3])) || dataOut == dIn1);
    // R6
    pick_leg2_chk: assert (!(!(ctrlIn[0] && ctrlIn[1]) && (ctrlIn[2] || ctrlIn[3])) || dataOut == dIn2);
    // R7
    pick_leg3_chk: assert (!((ctrlIn[0] && ctrlIn[1]) && (ctrlIn[2] || ctrlIn[3])) || dataOut == dIn3);
    // R1
    one_leg_copied_chk: assert (dataOut == dIn0 || dataOut == dIn1 || dataOut == dIn2 || dataOut == dIn3);
  end
endmodule

bind mux_logic_elem lem_chk #(.DATA_W(DATA_W)) u_chk (
  .dIn0   (dIn0),
  .dIn1   (dIn1),
  .dIn2   (dIn2),
  .dIn3   (dIn3),
  .ctrlIn (ctrlIn),
  .dataOut(dataOut),
  .strobes(strobes)
);

// File: tb/sim_mux_logic_elem.sv
`timescale 1ns/1ps
module sim_mux_logic_elem;
  logic clk = 1'b0;
  logic [0:0] dIn0, dIn1, dIn2, dIn3, dataOut;
  logic [3:0] ctrlIn;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mux_logic_elem #(.DATA_W(1)) u0 (
    .dIn0(dIn0), .dIn1(dIn1), .dIn2(dIn2), .dIn3(dIn3),
    .ctrlIn(ctrlIn), .dataOut(dataOut)
  );

  // Behavioural model: a queue of the four data values, indexed by a
  // number worked out from the control bits one at a time.
  function automatic logic model(input logic [7:0] v);
    logic q[$];
    int idx;
    for (int i = 0; i < 4; i++) q.push_back(v[i]);
    idx = 0;
    if (v[4] == 1'b1 && v[5] == 1'b1) idx += 1;
    if (v[6] == 1'b1 || v[7] == 1'b1) idx += 2;
    return q[idx];
  endfunction

  // v[3:0] drive dIn0..dIn3, v[7:4] drive ctrlIn[0..3].
  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    {ctrlIn, dIn3, dIn2, dIn1, dIn0} = v;
    #1;
  endtask

  function automatic string reqOf(input logic [7:0] v);
    logic a, o;
    a = v[4] & v[5];
    o = v[6] | v[7];
    if (!a && !o) return "R4";
    if (a && !o)  return "R5";
    if (!a && o)  return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dataOut=%b expected=%b (ctrl=%b data=%b%b%b%b)",
               req, got, exp, ctrlIn, dIn3, dIn2, dIn1, dIn0);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle state: all inputs low.
    apply(8'h00);
    check("R4", dataOut, 1'b0);

    // R1 R2 R3: exhaustive walk over all 256 vectors.
    for (int v = 0; v < 256; v++) begin
      apply(v[7:0]);
      check(reqOf(v[7:0]), dataOut, model(v[7:0]));
    end

    // R2: one control bit of the AND alone must not move the first level.
    apply(8'b0001_0001); check("R2", dataOut, 1'b1);
    apply(8'b0010_0001); check("R2", dataOut, 1'b1);
    // R3: either OR bit alone reaches the second pair.
    apply(8'b0100_0100); check("R3", dataOut, 1'b1);
    apply(8'b1000_0100); check("R3", dataOut, 1'b1);
    // R1: highest leg with all controls set.
    apply(8'b1111_1000); check("R1", dataOut, 1'b1);

    // R8: same vector after two different histories.
    apply(8'b1111_0111);
    apply(8'b0011_1010); check("R8", dataOut, 1'b1);
    apply(8'b0000_0000);
    apply(8'b0011_1010); check("R8", dataOut, 1'b1);

    // R9: toggle every unselected leg while holding each control setting.
    for (int c = 0; c < 16; c++) begin
      for (int sel = 0; sel < 2; sel++) begin
        logic [7:0] base;
        base = {c[3:0], 4'b0000};
        for (int o = 0; o < 16; o++) begin
          logic [7:0] v;
          v = {c[3:0], o[3:0]};
          v[model(base | 8'h01) ? 0 : (model(base | 8'h02) ? 1 : (model(base | 8'h04) ? 2 : 3))] = sel[0];
          apply(v);
          check("R9", dataOut, sel[0]);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule